// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block runs the sequential word-programming mode of a serial flash target. A front end, outside this block, frames transactions with the active-low select and assembles bytes. This block sees each frame as a start, a stream of whole bytes and an end. The first byte of a frame is the opcode.

A first word frame carries opcode ADh, a 24-bit address and two data bytes. The block forces that address even, programs the two bytes into an internal byte array and enters the mode. Each later ADh frame carries two data bytes only. Those bytes go to the next even pair of addresses. Programming starts only when the select returns high. A busy timer then stands in for the cell programming time.

While the mode is active, most opcodes are filtered out. The write enable latch, the mode flag and the busy flag appear in a status byte. A separate option makes the serial output line report ready or busy whenever the target is selected.

Top module: `wordprog_seq`

## Requirements
- R1: After reset the status byte is 00h, the ready/busy drive enable is low and every array byte reads FFh. Status bits: bit 0 busy, bit 1 write enable latch, bit 6 mode active, all other bits 0.
- R2: A one-byte frame 06h sets the write enable latch at frame end. This only happens when the mode is not active. A one-byte frame 04h clears the latch.
- R3: A six-byte frame ADh, A[23:16], A[15:8], A[7:0], D0, D1 enters the mode and programs D0 at the even address and D1 at the next address. It must arrive with the latch set, with busy clear and with the address inside the array. Otherwise it is ignored.
- R4: While the mode is active, a three-byte frame ADh, D0, D1 programs the next even pair, two above the previous pair. A word frame whose byte count is not exactly six (entry) or three (in mode) is discarded.
- R5: Programming ANDs the new data into the stored byte, so bits only go from 1 to 0.
- R6: Busy is set at the clock edge that first samples the select high after an accepted word frame. It stays 1 for BUSY_CYC cycles. ADh frames that end while busy is 1 are ignored and do not advance the address.
- R7: A one-byte frame 04h ends the mode, clearing bits 6 and 1. A later three-byte ADh frame then programs nothing.
- R8: While the mode is active, opcodes 06h, 70h and 80h are ignored. While the mode is active and ready/busy reporting is on, 05h is also ignored, so the status-read strobe stays low.
- R9: A one-byte frame 70h, outside the mode, turns ready/busy reporting on. From then on, while the select is low and no status read is in progress, the drive enable is 1 and the level is 0 for busy and 1 for ready. A one-byte frame 80h, outside the mode, turns reporting off.
- R10: A legal 05h opcode byte raises the status-read strobe from the next cycle until the frame ends.
- R11: When protection is on, a pair whose upper byte index is at or above the protection base is not programmed. The frame is ignored: no busy, no mode entry and no address advance.
- R12: Programming the top pair of the array (index DEPTH-2) ends the mode and clears the write enable latch.
- R13: Address bit 0 of an entry frame is ignored, so an odd address programs from the even address below it. Entry addresses with any bit set at or above bit log2(DEPTH) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Frame select, low while a frame is in progress |
| rx_valid | input | 1 | One assembled byte is present this cycle |
| rx_byte | input | 8 | Assembled byte |
| prot_en | input | 1 | Enables protection of the upper array region |
| prot_base | input | IDX_W (6) | First protected byte index |
| rd_addr | input | IDX_W (6) | Array read index |
| rd_data | output | 8 | Array byte at rd_addr |
| sts | output | 8 | Status byte (bit 0 busy, bit 1 latch, bit 6 mode) |
| sts_rd | output | 1 | A legal status read frame is in progress |
| rb_oe | output | 1 | Drive the serial output with the ready/busy level |
| rb_level | output | 1 | Ready/busy level, 1 ready, 0 busy |

## Verification
A wrong word index shows in the array read port as soon as the following pair has been programmed. The pair lands at the wrong index, or an untouched byte is left at FFh. A stale mode or latch flag shows in the status byte on the cycle after the frame end that should have changed it. It also shows one frame later as a word frame that is wrongly accepted or wrongly refused. A broken busy timer changes the number of cycles for which bit 0 and the ready/busy level show busy, and that count is measured exactly after every accepted word.

// File: rtl/wordprog_pkg.sv
package wordprog_pkg;
   localparam logic [7:0] OP_WORD  = 8'hAD;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_RB_ON = 8'h70;
   localparam logic [7:0] OP_RB_OFF = 8'h80;
   // frame lengths in bytes, opcode included
   localparam int FIRST_LEN = 6;
   localparam int NEXT_LEN  = 3;
   localparam int CNT_W     = 3;
endpackage

// File: rtl/wordprog_frame.sv
module wordprog_frame
   import wordprog_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   rx_valid,
   input  logic [7:0]             rx_byte,
   output logic                   frame_end,
   output logic [CNT_W-1:0]       frame_len,
   output logic [FIRST_LEN*8-1:0] frame_bytes,
   output logic                   head_valid,
   output logic [7:0]             head_byte
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             cs_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         cnt_q <= '0;
      end else begin
         cs_q <= cs_n;
         if (cs_n)
            cnt_q <= '0;
         else if (rx_valid && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   // one holding register per byte slot of the longest frame
   for (genvar i = 0; i < FIRST_LEN; i++) begin : g_slot
      logic [7:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q <= '0;
         else if (rx_valid && !cs_n && cnt_q == CNT_W'(i))
            slot_q <= rx_byte;
      end
      assign frame_bytes[i*8 +: 8] = slot_q;
   end

   assign frame_end  = cs_n & ~cs_q;
   assign frame_len  = cnt_q;
   assign head_valid = rx_valid & ~cs_n & (cnt_q == '0);
   assign head_byte  = rx_byte;
endmodule

// File: rtl/wordprog_busy.sv
module wordprog_busy #(
   parameter int BUSY_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TMR_W = $clog2(BUSY_CYC + 1);

   if (BUSY_CYC < 1) begin : g_bad_cyc
      $error("BUSY_CYC must be at least 1");
   end

   if (BUSY_CYC == 1) begin : g_flop
      logic b_q;
      always_ff @(posedge clk) begin
         if (!rst_n) b_q <= 1'b0;
         else        b_q <= start;
      end
      assign busy = b_q;
   end else begin : g_count
      logic [TMR_W-1:0] t_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            t_q <= '0;
         else if (start)
            t_q <= TMR_W'(BUSY_CYC);
         else if (t_q != '0)
            t_q <= t_q - 1'b1;
      end
      assign busy = (t_q != '0);
   end

   // R6: an accepted word makes busy visible on the next cycle
   a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R6: busy only rises because of a start
   a_r6_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/wordprog_array.sv
module wordprog_array #(
   parameter int DEPTH = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [7:0]       d0,
   input  logic [7:0]       d1,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data
);
   logic [DEPTH*8-1:0] mem_flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam int ODD = i % 2;
      logic [7:0] cell_q;
      logic [7:0] dsel;
      logic       hit;
      assign dsel = (ODD != 0) ? d1 : d0;
      assign hit  = we && (widx[IDX_W-1:1] == (IDX_W-1)'(i / 2));
      always_ff @(posedge clk) begin
         if (!rst_n)
            cell_q <= 8'hFF;
         else if (hit)
            cell_q <= cell_q & dsel;
      end
      assign mem_flat[i*8 +: 8] = cell_q;

      // R5: a stored byte never gains a 1 bit
      a_r5_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (cell_q & ~$past(cell_q)) == 8'h00);
   end

   assign rd_data = mem_flat[{rd_idx, 3'b000} +: 8];
endmodule

// File: rtl/wordprog_ctrl.sv
module wordprog_ctrl
   import wordprog_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   frame_end,
   input  logic [CNT_W-1:0]       frame_len,
   input  logic [FIRST_LEN*8-1:0] frame_bytes,
   input  logic                   head_valid,
   input  logic [7:0]             head_byte,
   input  logic                   busy,
   input  logic                   prot_en,
   input  logic [IDX_W-1:0]       prot_base,
   output logic                   prog_go,
   output logic [IDX_W-1:0]       prog_idx,
   output logic [7:0]             prog_d0,
   output logic [7:0]             prog_d1,
   output logic                   wel,
   output logic                   aai,
   output logic                   rb_en,
   output logic                   sts_rd
);
   logic [7:0]       op, b1, b2, b3, b4, b5;
   logic [23:0]      ent_addr;
   logic             range_ok;
   logic [IDX_W-1:0] ent_idx, tgt_idx, word_q;
   logic [IDX_W:0]   tgt_hi;
   logic             prot_hit, len_ok, word_cmd, single;
   logic             wren_cmd, wrdi_cmd, rbon_cmd, rboff_cmd, top_hit;

   assign op = frame_bytes[7:0];
   assign b1 = frame_bytes[15:8];
   assign b2 = frame_bytes[23:16];
   assign b3 = frame_bytes[31:24];
   assign b4 = frame_bytes[39:32];
   assign b5 = frame_bytes[47:40];

   assign ent_addr = {b1, b2, b3};
   assign range_ok = (ent_addr >> IDX_W) == 24'd0;
   assign ent_idx  = {ent_addr[IDX_W-1:1], 1'b0};
   assign tgt_idx  = aai ? word_q : ent_idx;
   assign tgt_hi   = {1'b0, tgt_idx} + {{IDX_W{1'b0}}, 1'b1};
   assign prot_hit = prot_en && (tgt_hi >= {1'b0, prot_base});
   assign len_ok   = aai ? (frame_len == CNT_W'(NEXT_LEN))
                         : (frame_len == CNT_W'(FIRST_LEN));

   assign word_cmd = frame_end && op == OP_WORD && len_ok && !busy && wel
                     && (aai || range_ok) && !prot_hit;
   assign single    = frame_end && frame_len == CNT_W'(1);
   assign wren_cmd  = single && op == OP_WREN && !aai;
   assign wrdi_cmd  = single && op == OP_WRDI;
   assign rbon_cmd  = single && op == OP_RB_ON && !aai;
   assign rboff_cmd = single && op == OP_RB_OFF && !aai;
   assign top_hit   = word_cmd && (tgt_idx == IDX_W'(DEPTH - 2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wel    <= 1'b0;
         aai    <= 1'b0;
         rb_en  <= 1'b0;
         sts_rd <= 1'b0;
         word_q <= '0;
      end else begin
         if (wrdi_cmd || top_hit)  wel <= 1'b0;
         else if (wren_cmd)        wel <= 1'b1;

         if (wrdi_cmd || top_hit)  aai <= 1'b0;
         else if (word_cmd)        aai <= 1'b1;

         if (word_cmd) word_q <= tgt_idx + IDX_W'(2);

         if (rbon_cmd)       rb_en <= 1'b1;
         else if (rboff_cmd) rb_en <= 1'b0;

         if (cs_n)
            sts_rd <= 1'b0;
         else if (head_valid && head_byte == OP_RDSR && !(aai && rb_en))
            sts_rd <= 1'b1;
      end
   end

   assign prog_go  = word_cmd;
   assign prog_idx = tgt_idx;
   assign prog_d0  = aai ? b1 : b4;
   assign prog_d1  = aai ? b2 : b5;

   // R3: the mode never runs without the write enable latch
   a_r3_mode_has_wel: assert property (@(posedge clk) disable iff (!rst_n)
      aai |-> wel);
   a_r3_entry_had_wel: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aai) |-> $past(wel));
   // R13: the running word index stays even
   a_r13_word_even: assert property (@(posedge clk) disable iff (!rst_n)
      aai |-> (word_q[0] == 1'b0));
   // R8: no status read while hardware ready/busy reporting owns the mode
   a_r8_no_rdsr_hw: assert property (@(posedge clk) disable iff (!rst_n)
      (aai && rb_en) |-> !sts_rd);
   // R7: a write-disable frame leaves the mode and the latch clear
   a_r7_wrdi_exits: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && frame_len == CNT_W'(1) && op == OP_WRDI) |=> (!aai && !wel));
   // R6: no word is accepted while busy
   a_r6_no_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> !busy);
endmodule

// File: rtl/wordprog_seq.sv
module wordprog_seq
   import wordprog_pkg::*;
#(
   parameter int DEPTH    = 64,
   parameter int BUSY_CYC = 20,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_byte,
   input  logic             prot_en,
   input  logic [IDX_W-1:0] prot_base,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [7:0]       rd_data,
   output logic [7:0]       sts,
   output logic             sts_rd,
   output logic             rb_oe,
   output logic             rb_level
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 4");
   end
   if (IDX_W > 24) begin : g_bad_span
      $error("DEPTH exceeds the 24-bit address space");
   end

   logic                   frame_end, head_valid;
   logic [CNT_W-1:0]       frame_len;
   logic [FIRST_LEN*8-1:0] frame_bytes;
   logic [7:0]             head_byte;
   logic                   busy, prog_go, wel, aai, rb_en;
   logic [IDX_W-1:0]       prog_idx;
   logic [7:0]             prog_d0, prog_d1;

   wordprog_frame u_frame (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .frame_end(frame_end), .frame_len(frame_len),
      .frame_bytes(frame_bytes), .head_valid(head_valid), .head_byte(head_byte)
   );

   wordprog_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .frame_end(frame_end),
      .frame_len(frame_len), .frame_bytes(frame_bytes),
      .head_valid(head_valid), .head_byte(head_byte), .busy(busy),
      .prot_en(prot_en), .prot_base(prot_base), .prog_go(prog_go),
      .prog_idx(prog_idx), .prog_d0(prog_d0), .prog_d1(prog_d1),
      .wel(wel), .aai(aai), .rb_en(rb_en), .sts_rd(sts_rd)
   );

   wordprog_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(prog_go), .busy(busy)
   );

   wordprog_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
      .clk(clk), .rst_n(rst_n), .we(prog_go), .widx(prog_idx),
      .d0(prog_d0), .d1(prog_d1), .rd_idx(rd_addr), .rd_data(rd_data)
   );

   // bit 6 mode, bit 1 latch, bit 0 busy
   assign sts      = {1'b0, aai, 4'b0000, wel, busy};
   assign rb_oe    = rb_en & ~cs_n & ~sts_rd;
   assign rb_level = ~busy;

   // R9: the ready/busy level shows busy for a whole programming window
   a_r9_level_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |=> !rb_level);
endmodule

// File: tb/wordprog_seq_bench.sv
module wordprog_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       prot_en = 1'b0;
   logic [5:0] prot_base = 6'd0;
   logic [5:0] rd_addr = 6'd0;
   logic [7:0] rd_data, sts;
   logic       sts_rd, rb_oe, rb_level;

   localparam int BUSY = 20;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wordprog_seq #(.DEPTH(64), .BUSY_CYC(BUSY)) u_wordprog_seq (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .prot_en(prot_en), .prot_base(prot_base),
      .rd_addr(rd_addr), .rd_data(rd_data), .sts(sts), .sts_rd(sts_rd),
      .rb_oe(rb_oe), .rb_level(rb_level)
   );

   // {programs, byte count, bytes (first at the top), status after}
   localparam logic [59:0] VEC [11] = '{
      {1'b0, 3'd1, 48'h06_00_00_00_00_00, 8'h02},   // R2 latch on
      {1'b0, 3'd1, 48'h04_00_00_00_00_00, 8'h00},   // R2 latch off
      {1'b0, 3'd6, 48'hAD_00_00_05_A5_3C, 8'h00},   // R3 no latch
      {1'b0, 3'd1, 48'h06_00_00_00_00_00, 8'h02},
      {1'b1, 3'd6, 48'hAD_00_00_05_A5_3C, 8'h42},   // R3 entry at 4
      {1'b0, 3'd1, 48'h06_00_00_00_00_00, 8'h42},   // R8 ignored
      {1'b0, 3'd1, 48'h70_00_00_00_00_00, 8'h42},   // R8 ignored
      {1'b1, 3'd3, 48'hAD_11_22_00_00_00, 8'h42},   // R4 next pair
      {1'b0, 3'd2, 48'hAD_99_00_00_00_00, 8'h42},   // R4 short frame
      {1'b0, 3'd1, 48'h04_00_00_00_00_00, 8'h00},   // R7 exit
      {1'b0, 3'd3, 48'hAD_77_88_00_00_00, 8'h00}    // R7 no effect
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_frame(int n, logic [47:0] b);
      @(negedge clk) cs_n = 1'b0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_byte  = b[47-8*k -: 8];
      end
      @(negedge clk) rx_valid = 1'b0;
      @(negedge clk) cs_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (sts[0] && cyc < 1000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic mem_is(string req, int a, logic [7:0] exp);
      rd_addr = 6'(a);
      #0.5;
      check(req, rd_data, exp);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 status", sts, 8'h00);
      check("R1 rb_oe", rb_oe, 1'b0);
      mem_is("R1 byte 0", 0, 8'hFF);
      mem_is("R1 byte 63", 63, 8'hFF);

      for (int v = 0; v < 11; v++) begin
         send_frame(int'(VEC[v][58:56]), VEC[v][55:8]);
         wait_idle(c);
         check($sformatf("R6 busy length vector %0d", v), c, VEC[v][59] ? BUSY : 0);
         check($sformatf("R2/R3/R4/R7/R8 status vector %0d", v), sts, VEC[v][7:0]);
      end
      mem_is("R3 even low byte", 4, 8'hA5);
      mem_is("R3 odd high byte", 5, 8'h3C);
      mem_is("R4 next low", 6, 8'h11);
      mem_is("R4 next high", 7, 8'h22);
      mem_is("R7 no write after exit", 8, 8'hFF);

      // R5 AND into programmed bytes
      send_frame(1, 48'h06_00_00_00_00_00);
      send_frame(6, 48'hAD_00_00_04_F0_0F);
      wait_idle(c);
      mem_is("R5 and low", 4, 8'hA0);
      mem_is("R5 and high", 5, 8'h0C);
      send_frame(1, 48'h04_00_00_00_00_00);

      // R6 word frames during busy are dropped
      send_frame(1, 48'h06_00_00_00_00_00);
      send_frame(6, 48'hAD_00_00_10_55_AA);
      send_frame(3, 48'hAD_99_99_00_00_00);
      check("R6 still busy", sts[0], 1'b1);
      wait_idle(c);
      send_frame(3, 48'hAD_66_77_00_00_00);
      wait_idle(c);
      check("R6 busy length", c, BUSY);
      mem_is("R6 first low", 16, 8'h55);
      mem_is("R6 first high", 17, 8'hAA);
      mem_is("R6 next low", 18, 8'h66);
      mem_is("R6 next high", 19, 8'h77);
      mem_is("R6 no extra", 20, 8'hFF);
      send_frame(1, 48'h04_00_00_00_00_00);

      // R11 protection
      prot_en = 1'b1;
      prot_base = 6'h21;
      send_frame(1, 48'h06_00_00_00_00_00);
      send_frame(6, 48'hAD_00_00_1E_C3_3C);
      wait_idle(c);
      check("R11 unprotected pair busy", c, BUSY);
      send_frame(3, 48'hAD_01_02_00_00_00);
      wait_idle(c);
      check("R11 protected no busy", c, 0);
      check("R11 mode kept", sts, 8'h42);
      mem_is("R11 unprotected programmed", 30, 8'hC3);
      mem_is("R11 protected low", 32, 8'hFF);
      mem_is("R11 protected high", 33, 8'hFF);
      send_frame(1, 48'h04_00_00_00_00_00);
      send_frame(1, 48'h06_00_00_00_00_00);
      send_frame(6, 48'hAD_00_00_20_00_00);
      check("R11 entry refused", sts, 8'h02);
      send_frame(1, 48'h04_00_00_00_00_00);
      prot_en = 1'b0;

      // R12 and R13 top pair from an odd address
      send_frame(1, 48'h06_00_00_00_00_00);
      send_frame(6, 48'hAD_00_00_3F_12_34);
      wait_idle(c);
      check("R12 mode ends at top", sts, 8'h00);
      mem_is("R13 even forced low", 62, 8'h12);
      mem_is("R13 even forced high", 63, 8'h34);
      // R13 out of range
      send_frame(1, 48'h06_00_00_00_00_00);
      send_frame(6, 48'hAD_01_00_00_00_00);
      check("R13 out of range refused", sts, 8'h02);
      mem_is("R13 byte 0 untouched", 0, 8'hFF);
      send_frame(1, 48'h04_00_00_00_00_00);

      // R10 status read outside the mode
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk) begin rx_valid = 1'b1; rx_byte = 8'h05; end
      @(negedge clk) rx_valid = 1'b0;
      check("R10 sts_rd high", sts_rd, 1'b1);
      @(negedge clk) cs_n = 1'b1;
      @(negedge clk);
      check("R10 sts_rd low after frame", sts_rd, 1'b0);

      // R9 ready/busy reporting
      send_frame(1, 48'h70_00_00_00_00_00);
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk);
      check("R9 rb_oe selected", rb_oe, 1'b1);
      check("R9 ready level", rb_level, 1'b1);
      cs_n = 1'b1;
      @(negedge clk);
      check("R9 rb_oe deselected", rb_oe, 1'b0);
      send_frame(1, 48'h06_00_00_00_00_00);
      send_frame(6, 48'hAD_00_00_30_AB_CD);
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk);
      check("R9 busy level", rb_level, 1'b0);
      check("R9 rb_oe while busy", rb_oe, 1'b1);
      // R8 status read refused in the mode with reporting on
      @(negedge clk) begin rx_valid = 1'b1; rx_byte = 8'h05; end
      @(negedge clk) rx_valid = 1'b0;
      check("R8 rdsr ignored", sts_rd, 1'b0);
      @(negedge clk) cs_n = 1'b1;
      @(negedge clk);
      wait_idle(c);
      send_frame(1, 48'h04_00_00_00_00_00);
      check("R7 exit status", sts, 8'h00);
      send_frame(1, 48'h80_00_00_00_00_00);
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk);
      check("R9 reporting off", rb_oe, 1'b0);
      cs_n = 1'b1;
      mem_is("R9 word programmed", 48, 8'hAB);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule